// File: doc/BRIEF.md
# Maskable Interrupt Aggregator with Programmable Pin Polarity

This block gathers eight single-cycle event pulses into one interrupt pin. Each pulse sets a sticky status bit. A read of the interrupt word clears the status bits. The same 16-bit word also holds one enable bit per source: the status flags sit in the low byte and the enables sit in the high byte. A separate control word holds one polarity bit, which selects whether the pin is active-high or active-low.

The pin behaves like an open-drain output. While no enabled source is pending, the pad is released to high impedance and a board-level pull resistor sets its level. While an enabled source is pending, the pad is driven to the programmed active level. The output enable and the level are both registered, so the pin follows the internal state one clock later.

Software reaches the two words through a simple synchronous register port. The port has an address, read and write strobes, write data, and combinational read data.

Top module: `irq_aggregator`

## Requirements
- R1: A one-cycle pulse on `evt_i[k]` sets status bit k at that clock edge. The bit then stays set until the interrupt word is read.
- R2: A read at the interrupt address (default 17) returns {enables[15:8], status[7:0]} as they were before the edge. At that edge, every status bit is cleared, except a bit whose event pulse arrives in the same cycle; such a bit stays set.
- R3: A write to the interrupt address loads `wdata_i[15:8]` into the enables. Write data in bits 7:0 has no effect on the status bits.
- R4: After reset, the enables are 0, the status bits are 0, the polarity bit is 0 (active-low) and the output enable is 0.
- R5: `irq_oe_o` is 1 in the cycle after a cycle in which (status & enables) is non-zero, and 0 otherwise. A cleared enable suppresses its source. `irq_pad_o` is high impedance whenever `irq_oe_o` is 0.
- R6: Bit 14 of the control word (default address 16) is the polarity: 1 selects active-high and 0 selects active-low. `irq_lvl_o` equals the polarity of the previous cycle, and the pad is driven to that level while it is enabled. A read of the control word returns only bit 14; all other bits read 0.
- R7: A read of any other address returns 16'hFFFF. A write to any other address leaves the enables and the polarity unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | Event pulses, one per source |
| addr_i | input | 5 | Register address |
| rd_en_i | input | 1 | Read strobe (clears status when reading the interrupt word) |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from the address |
| irq_oe_o | output | 1 | Registered pad output enable |
| irq_lvl_o | output | 1 | Registered level driven while enabled |
| irq_pad_o | output | 1 | Interrupt pad, high impedance when not asserted |

## Verification
The bench aims at several corner cases.

- **Event in the same cycle as a clearing read.** A design that clears unconditionally would lose that event and leave the pin silent.
- **Write to the interrupt word with all-ones data.** If the status byte were writable, spurious pending bits would appear and the pin would assert with no event.
- **Enable dropped while a status bit is pending.** This must release the pad one cycle later. A missing output register would shift every pin transition by a cycle, and the per-clock comparison of `irq_oe_o` catches that.
- **Polarity flips and writes to unmapped addresses.** These are checked through the level output and readback. A wrong bit position or a decode that aliases onto a live register shows up as a readback mismatch.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned NUM_SRC_DEF   = 8;
  localparam int unsigned ADDR_W_DEF    = 5;
  localparam int unsigned CTRL_ADDR_DEF = 16;
  localparam int unsigned IRQ_ADDR_DEF  = 17;
  localparam int unsigned POL_BIT_DEF   = 14;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_IRQ  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  output logic [N-1:0] sts_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    logic sts_q;
    // a pulse in the clearing cycle wins over the clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sts_q <= 1'b0;
      else         sts_q <= evt_i[k] | (sts_q & ~clr_i);
    end
    assign sts_o[k] = sts_q;
  end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_agg_pkg::*;
#(
  parameter int unsigned N         = NUM_SRC_DEF,
  parameter int unsigned ADDR_W    = ADDR_W_DEF,
  parameter int unsigned CTRL_ADDR = CTRL_ADDR_DEF,
  parameter int unsigned IRQ_ADDR  = IRQ_ADDR_DEF,
  parameter int unsigned POL_BIT   = POL_BIT_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [2*N-1:0]    wdata_i,
  input  logic [N-1:0]      sts_i,
  output logic [2*N-1:0]    rdata_o,
  output logic              clr_o,
  output logic [N-1:0]      en_o,
  output logic              pol_o
);
  localparam int unsigned REG_W = 2 * N;

  reg_sel_e     sel;
  logic [N-1:0] en_q;
  logic         pol_q;
  logic         unused_wdata;

  always_comb begin
    if (addr_i == ADDR_W'(IRQ_ADDR))       sel = SEL_IRQ;
    else if (addr_i == ADDR_W'(CTRL_ADDR)) sel = SEL_CTRL;
    else                                   sel = SEL_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      pol_q <= 1'b0;
    end else if (wr_en_i) begin
      if (sel == SEL_IRQ)  en_q  <= wdata_i[REG_W-1:N];
      if (sel == SEL_CTRL) pol_q <= wdata_i[POL_BIT];
    end
  end

  always_comb begin
    rdata_o = '1;
    unique case (sel)
      SEL_IRQ:  rdata_o = {en_q, sts_i};
      SEL_CTRL: begin
        rdata_o          = '0;
        rdata_o[POL_BIT] = pol_q;
      end
      default:  rdata_o = '1;
    endcase
  end

  assign clr_o        = rd_en_i && (sel == SEL_IRQ);
  assign en_o         = en_q;
  assign pol_o        = pol_q;
  assign unused_wdata = ^wdata_i;
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sts_i,
  input  logic [N-1:0] en_i,
  input  logic         pol_i,
  output logic         oe_o,
  output logic         lvl_o,
  output wire          pad_o
);
  logic oe_q, lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q  <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      oe_q  <= |(sts_i & en_i);
      lvl_q <= pol_i;
    end
  end

  assign oe_o  = oe_q;
  assign lvl_o = lvl_q;
  assign pad_o = oe_q ? lvl_q : 1'bz;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC   = NUM_SRC_DEF,
  parameter int unsigned ADDR_W    = ADDR_W_DEF,
  parameter int unsigned CTRL_ADDR = CTRL_ADDR_DEF,
  parameter int unsigned IRQ_ADDR  = IRQ_ADDR_DEF,
  parameter int unsigned POL_BIT   = POL_BIT_DEF,
  localparam int unsigned REG_W    = 2 * NUM_SRC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_oe_o,
  output logic              irq_lvl_o,
  output wire               irq_pad_o
);
  logic [NUM_SRC-1:0] sts_q;
  logic [NUM_SRC-1:0] en_q;
  logic               pol_q;
  logic               clr;

  irq_status_bank #(.N(NUM_SRC)) u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .clr_i  (clr),
    .sts_o  (sts_q)
  );

  irq_regfile #(
    .N(NUM_SRC), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
    .IRQ_ADDR(IRQ_ADDR), .POL_BIT(POL_BIT)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .rd_en_i (rd_en_i),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .sts_i   (sts_q),
    .rdata_o (rdata_o),
    .clr_o   (clr),
    .en_o    (en_q),
    .pol_o   (pol_q)
  );

  irq_pin_drv #(.N(NUM_SRC)) u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sts_i  (sts_q),
    .en_i   (en_q),
    .pol_i  (pol_q),
    .oe_o   (irq_oe_o),
    .lvl_o  (irq_lvl_o),
    .pad_o  (irq_pad_o)
  );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int unsigned N         = 8,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned CTRL_ADDR = 16,
  parameter int unsigned IRQ_ADDR  = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N-1:0]      evt_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic [2*N-1:0]    wdata_i,
  input logic [N-1:0]      sts_i,
  input logic [N-1:0]      en_i,
  input logic              pol_i,
  input logic              oe_i,
  input logic              lvl_i
);
  logic hit_irq, hit_ctrl;
  assign hit_irq  = addr_i == ADDR_W'(IRQ_ADDR);
  assign hit_ctrl = addr_i == ADDR_W'(CTRL_ADDR);

  AST_EVT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((sts_i & $past(evt_i)) == $past(evt_i))); // R1
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && hit_irq) |=> (($past(sts_i) & ~sts_i) == '0)); // R1
  AST_READ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && hit_irq) |=> (sts_i == $past(evt_i))); // R2
  AST_STS_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (evt_i == '0) && !(rd_en_i && hit_irq)) |=> $stable(sts_i)); // R3
  AST_EN_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit_irq) |=> (en_i == $past(wdata_i[2*N-1:N]))); // R3
  AST_OE_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (oe_i == |($past(sts_i & en_i)))); // R5
  AST_LVL_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (lvl_i == $past(pol_i))); // R6
  AST_UNMAPPED_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hit_irq && !hit_ctrl) |=> ($stable(en_i) && $stable(pol_i))); // R7
endmodule

bind irq_aggregator irq_aggregator_chk #(
  .N(NUM_SRC), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .IRQ_ADDR(IRQ_ADDR)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .evt_i   (evt_i),
  .addr_i  (addr_i),
  .rd_en_i (rd_en_i),
  .wr_en_i (wr_en_i),
  .wdata_i (wdata_i),
  .sts_i   (sts_q),
  .en_i    (en_q),
  .pol_i   (pol_q),
  .oe_i    (irq_oe_o),
  .lvl_i   (irq_lvl_o)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  localparam logic [4:0] A_CTRL = 5'd16;
  localparam logic [4:0] A_IRQ  = 5'd17;
  localparam logic [4:0] A_NONE = 5'd3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  evt = '0;
  logic [4:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        oe, lvl;
  wire         pad;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference state
  logic [7:0] m_sts = '0, m_en = '0;
  logic       m_pol = 1'b0, m_oe = 1'b0, m_lvl = 1'b0;

  always #5 clk = ~clk;

  irq_aggregator u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt), .addr_i(addr),
    .rd_en_i(rd), .wr_en_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_oe_o(oe), .irq_lvl_o(lvl), .irq_pad_o(pad)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] m_read(input logic [4:0] a);
    if (a == A_IRQ)  return {m_en, m_sts};
    if (a == A_CTRL) return {1'b0, m_pol, 14'b0};
    return 16'hFFFF;
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    if (a == A_IRQ)  return "R2";
    if (a == A_CTRL) return "R6";
    return "R7";
  endfunction

  // one cycle: drive after negedge, check comb read, clock, update model, check pin
  task automatic cyc(input logic [7:0] e, input logic r, input logic w,
                     input logic [4:0] a, input logic [15:0] d, input string tag);
    evt = e; rd = r; wr = w; addr = a; wdata = d;
    #1;
    chk(tag, rdata, m_read(a));
    @(posedge clk);
    m_oe  = |(m_sts & m_en);
    m_lvl = m_pol;
    if (r && a == A_IRQ) m_sts = e;
    else                 m_sts = m_sts | e;
    if (w && a == A_IRQ)  m_en  = d[15:8];
    if (w && a == A_CTRL) m_pol = d[14];
    @(negedge clk);
    chk("R5", {15'b0, oe}, {15'b0, m_oe});
    chk("R6", {15'b0, lvl}, {15'b0, m_lvl});
  endtask

  task automatic idle(input string tag);
    cyc(8'h00, 1'b0, 1'b0, A_NONE, 16'h0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    // R4 reset state
    chk("R4", {15'b0, oe}, 16'h0);
    cyc(8'h00, 1'b1, 1'b0, A_IRQ,  16'h0, "R4");
    cyc(8'h00, 1'b1, 1'b0, A_CTRL, 16'h0, "R4");

    // R1 latch with enables off, pin must stay released
    cyc(8'h05, 1'b0, 1'b0, A_NONE, 16'h0, "R1");
    idle("R1"); idle("R1");
    cyc(8'h00, 1'b0, 1'b0, A_IRQ, 16'h0, "R1");
    chk("R1", rdata, 16'h0005);

    // R3 write all ones: enables load, status byte untouched
    cyc(8'h00, 1'b0, 1'b1, A_IRQ, 16'hFFFF, "R3");
    cyc(8'h00, 1'b0, 1'b0, A_IRQ, 16'h0, "R3");
    chk("R3", rdata, 16'hFF05);
    idle("R5");

    // R5 dropping the enable of the only pending sources releases the pin
    cyc(8'h00, 1'b0, 1'b1, A_IRQ, 16'hFA00, "R5");
    idle("R5"); idle("R5");
    chk("R5", {15'b0, oe}, 16'h0);

    // R2 read clears, with concurrent event on bit 1 surviving
    cyc(8'h00, 1'b0, 1'b1, A_IRQ, 16'hFF00, "R2");
    cyc(8'h02, 1'b1, 1'b0, A_IRQ, 16'h0, "R2");
    cyc(8'h00, 1'b0, 1'b0, A_IRQ, 16'h0, "R2");
    chk("R2", rdata, 16'hFF02);
    cyc(8'h00, 1'b1, 1'b0, A_IRQ, 16'h0, "R2");
    idle("R2"); idle("R2");

    // R6 polarity to active-high and back
    cyc(8'h00, 1'b0, 1'b1, A_CTRL, 16'hBFFF, "R6");
    cyc(8'h00, 1'b1, 1'b0, A_CTRL, 16'h0, "R6");
    chk("R6", rdata, 16'h0000);
    cyc(8'h00, 1'b0, 1'b1, A_CTRL, 16'h4000, "R6");
    cyc(8'h80, 1'b1, 1'b0, A_CTRL, 16'h0, "R6");
    chk("R6", rdata, 16'h4000);
    idle("R6"); idle("R6");
    chk("R6", {14'b0, oe, lvl}, 16'h0003);

    // R7 unmapped read and write
    cyc(8'h00, 1'b0, 1'b1, A_NONE, 16'h0000, "R7");
    cyc(8'h00, 1'b1, 1'b0, A_NONE, 16'h0, "R7");
    chk("R7", rdata, 16'hFFFF);
    cyc(8'h00, 1'b0, 1'b0, A_IRQ, 16'h0, "R7");
    chk("R7", rdata, 16'hFF80);
    cyc(8'h00, 1'b0, 1'b0, A_CTRL, 16'h0, "R7");
    chk("R7", rdata, 16'h4000);

    // mixed traffic against the reference model
    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  e;
      logic [4:0]  a;
      logic [1:0]  pick;
      logic        r, w;
      logic [15:0] d;
      e    = (($urandom % 4) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      pick = 2'($urandom % 4);
      a    = (pick == 0) ? A_CTRL : (pick == 3) ? A_NONE : A_IRQ;
      r    = ($urandom % 3) == 0;
      w    = ($urandom % 5) == 0;
      d    = 16'($urandom);
      cyc(e, r, w, a, d, tag_of(a));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule